// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a word-wide read/write port. Each pin has a direction bit. Output levels change only through separate write-one-to-set and write-one-to-clear locations. The block can also report the synchronized level of every pin.

Each pin can be armed to capture rising edges, falling edges or both into a sticky status bit. Software clears that bit by writing a one to it. One interrupt line is the OR of every captured status bit. A two-bit alternate-function code per pin is stored for the pad multiplexing logic outside the block.

Registers are grouped by function. Every group is `NPIN/32` words long. The only exception is the alternate-function group, which packs 16 pins per word and so takes twice as many words.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NW = NPIN/32, register word index = group × NW + (pin ÷ 32), and byte address = 4 × word index. The group order is: level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, edge status 6, alternate function 7. The alternate-function group spans 2 × NW words. Reads outside 9 × NW words return zero, and writes there change nothing.
- R2: A direction bit of 1 makes the pin an output (`pad_oe` high) and 0 makes it an input. Each bit is written and read back directly.
- R3: Writing 1 to a bit of the set group drives that bit of `pad_out` high from the next cycle. Zero bits leave the output unchanged. Reading the set group or the clear group returns the current output latch.
- R4: Writing 1 to a bit of the clear group drives that bit of `pad_out` low from the next cycle. Zero bits leave the output unchanged.
- R5: The level group returns each pad input after a two-flop synchronizer. A change on `pad_in` is first visible two clock edges later. Writes to the level group are ignored.
- R6: A status bit sets on a rising edge of the synchronized pin when its rising enable is 1, and on a falling edge when its falling enable is 1. An edge is seen one edge after the level shows it, so the status bit sets three clock edges after the pad changes. With both enables set, both directions are captured.
- R7: An edge on a pin whose matching enable is 0 does not set its status bit.
- R8: Writing 1 to a status bit clears it, and zero bits are untouched. If an edge arrives in the same cycle as the clearing write, the bit stays set.
- R9: The alternate-function group holds 2 bits per pin. Pin p uses word p ÷ 16 of the group, bits [(p mod 16)×2 +: 2]. It reads back as written.
- R10: After reset, every register (direction, output latch, rising and falling enables, status and alternate function) reads 0, `pad_oe` and `pad_out` are 0, and `irq` is low.
- R11: `irq` is the OR of all status bits, one cycle after the status changes. It stays high until every status bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW = clog2(36 × NPIN/32) | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pad_in | input | NPIN | Asynchronous pad inputs |
| pad_out | output | NPIN | Output latch driven to the pads |
| pad_oe | output | NPIN | Per-pin output enable (direction) |
| irq | output | 1 | OR of all captured edge status bits |

## Verification
The bench aims a clearing write at the exact cycle in which a new rising edge reaches the status logic. A design that lets the clear win would read back zero and drop the interrupt. It checks the level register one cycle and two cycles after a pad change. A synchronizer that is too short or too long shows up as a wrong value at one of those two samples.

Set and clear writes carrying zero bits, a write to the read-only level group and a write beyond the alternate-function group must all leave the readback unchanged. This catches decoders that misplace the alternate-function span or treat set and clear as plain stores. Partial clearing with two status bits pending must keep `irq` high. Falls on a rise-only pin must not be captured.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned GROUP_COUNT = 9;   // seven single groups + double-width alt group

    typedef enum logic [3:0] {
        GRP_LEVEL = 4'd0,
        GRP_DIR   = 4'd1,
        GRP_SET   = 4'd2,
        GRP_CLR   = 4'd3,
        GRP_RISE  = 4'd4,
        GRP_FALL  = 4'd5,
        GRP_STAT  = 4'd6,
        GRP_ALT   = 4'd7,
        GRP_NONE  = 4'd15
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [7:0] word;   // word within the group
    } reg_sel_t;

    // Split a word index into group and word-within-group.
    function automatic reg_sel_t decode_word(input int unsigned widx, input int unsigned nw);
        reg_sel_t s;
        if (widx < 7 * nw) begin
            s.grp  = grp_e'(4'(widx / nw));
            s.word = 8'(widx % nw);
        end else if (widx < GROUP_COUNT * nw) begin
            s.grp  = GRP_ALT;
            s.word = 8'(widx - 7 * nw);
        end else begin
            s.grp  = GRP_NONE;
            s.word = 8'd0;
        end
        return s;
    endfunction

    function automatic int unsigned grp_byte(input grp_e g, input int unsigned w, input int unsigned nw);
        return (int'(g) * nw + w) * 4;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] hit;

    assign hit = (rise & en_rise) | (fall & en_fall);

    // a fresh edge wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | hit;
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN = 64,
    localparam int unsigned NW   = NPIN / 32,
    localparam int unsigned NALT = 2 * NW,
    localparam int unsigned AW   = $clog2(GROUP_COUNT * NW * 4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            irq
);
    reg_sel_t sel;
    assign sel = decode_word(32'(reg_addr[AW-1:2]), NW);

    logic [NW-1:0][31:0]   dir_q, out_q, rise_q, fall_q, stat_w;
    logic [NALT-1:0][31:0] alt_q;
    logic [NPIN-1:0]       lvl, rise_p, fall_p;

    gpio_bank_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .level  (lvl),
        .rise   (rise_p),
        .fall   (fall_p)
    );

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic hit_w;
        logic [31:0] clr_bits;
        assign hit_w    = reg_we && (sel.word == 8'(g));
        assign clr_bits = (hit_w && sel.grp == GRP_STAT) ? reg_wdata : 32'd0;

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[g]  <= '0;
                out_q[g]  <= '0;
                rise_q[g] <= '0;
                fall_q[g] <= '0;
            end else if (hit_w) begin
                case (sel.grp)
                    GRP_DIR:  dir_q[g]  <= reg_wdata;
                    GRP_SET:  out_q[g]  <= out_q[g] | reg_wdata;
                    GRP_CLR:  out_q[g]  <= out_q[g] & ~reg_wdata;
                    GRP_RISE: rise_q[g] <= reg_wdata;
                    GRP_FALL: fall_q[g] <= reg_wdata;
                    default:  ;
                endcase
            end
        end

        gpio_bank_edge #(.W(32)) u_edge (
            .clk     (clk),
            .rst     (rst),
            .rise    (rise_p[g*32 +: 32]),
            .fall    (fall_p[g*32 +: 32]),
            .en_rise (rise_q[g]),
            .en_fall (fall_q[g]),
            .clr     (clr_bits),
            .status  (stat_w[g])
        );
    end

    for (genvar a = 0; a < NALT; a++) begin : g_alt
        always_ff @(posedge clk) begin
            if (rst)
                alt_q[a] <= '0;
            else if (reg_we && sel.grp == GRP_ALT && sel.word == 8'(a))
                alt_q[a] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (sel.word == 8'(i)) begin
                case (sel.grp)
                    GRP_LEVEL:        reg_rdata = lvl[i*32 +: 32];
                    GRP_DIR:          reg_rdata = dir_q[i];
                    GRP_SET, GRP_CLR: reg_rdata = out_q[i];
                    GRP_RISE:         reg_rdata = rise_q[i];
                    GRP_FALL:         reg_rdata = fall_q[i];
                    GRP_STAT:         reg_rdata = stat_w[i];
                    default:          ;
                endcase
            end
        end
        for (int i = 0; i < NALT; i++) begin
            if (sel.grp == GRP_ALT && sel.word == 8'(i)) reg_rdata = alt_q[i];
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign irq     = |stat_w;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN = 64,
    localparam int unsigned NW  = NPIN / 32,
    localparam int unsigned AW  = $clog2(GROUP_COUNT * NW * 4)
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic            irq
);
    localparam int unsigned SET0  = grp_byte(GRP_SET, 0, NW);
    localparam int unsigned CLR0  = grp_byte(GRP_CLR, 0, NW);
    localparam int unsigned STATL = grp_byte(GRP_STAT, 0, NW);
    localparam int unsigned STATH = grp_byte(GRP_ALT, 0, NW);

    logic stat_wr;
    assign stat_wr = reg_we && (32'(reg_addr) >= STATL) && (32'(reg_addr) < STATH);

    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        (reg_we && 32'(reg_addr) == SET0 && reg_wdata[0]) |=> pad_out[0]);

    a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (rst)
        (reg_we && 32'(reg_addr) == CLR0 && reg_wdata[0]) |=> !pad_out[0]);

    a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(pad_oe));

    a_r11_irq_drops_on_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(stat_wr));

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0 && pad_out == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    localparam int PERIOD = 10;
    localparam int NPIN   = 64;
    localparam int AW     = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_we = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    gpio_bank_ctrl #(.NPIN(NPIN)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // Byte map for 64 pins (2 words per group):
    // level 0/4, dir 8/12, set 16/20, clear 24/28, rise 32/36,
    // fall 40/44, status 48/52, alt 56..68, beyond 72 unmapped.
    typedef struct packed {
        logic [3:0]    req;
        logic [AW-1:0] waddr;
        logic [31:0]   wdata;
        logic [AW-1:0] raddr;
        logic [31:0]   exp;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{4'd2, 7'd8,  32'hA5A5_0F0F, 7'd8,  32'hA5A5_0F0F},  // R2 word 0
        '{4'd2, 7'd12, 32'h0000_0003, 7'd12, 32'h0000_0003},  // R2 word 1
        '{4'd3, 7'd20, 32'h0000_00FF, 7'd20, 32'h0000_00FF},  // R3 set
        '{4'd3, 7'd20, 32'h0000_0000, 7'd20, 32'h0000_00FF},  // R3 zero bits
        '{4'd4, 7'd28, 32'h0000_000F, 7'd20, 32'h0000_00F0},  // R4 clear
        '{4'd4, 7'd28, 32'h0000_0000, 7'd28, 32'h0000_00F0},  // R4 zero bits
        '{4'd5, 7'd0,  32'hFFFF_FFFF, 7'd0,  32'h0000_0000},  // R5 level write ignored
        '{4'd9, 7'd56, 32'h0000_00E4, 7'd56, 32'h0000_00E4},  // R9 pins 0..3
        '{4'd9, 7'd68, 32'hC000_0000, 7'd68, 32'hC000_0000},  // R9 pin 63
        '{4'd1, 7'd72, 32'hFFFF_FFFF, 7'd72, 32'h0000_0000},  // R1 unmapped
        '{4'd1, 7'd40, 32'h0000_0010, 7'd40, 32'h0000_0010}   // R1 fall group word 0
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state on every mapped word
        for (int a = 0; a < 72; a += 4) begin
            rd(AW'(a), v);
            check($sformatf("R10 reset read addr %0d", a), 64'(v), 64'd0);
        end
        check("R10 pad_oe after reset", pad_oe, 64'd0);
        check("R10 pad_out after reset", pad_out, 64'd0);
        check("R10 irq after reset", 64'(irq), 64'd0);

        // vector table: write, then read back
        for (int i = 0; i < 11; i++) begin
            wr(VEC[i].waddr, VEC[i].wdata);
            rd(VEC[i].raddr, v);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(v), 64'(VEC[i].exp));
        end
        check("R2 pad_oe pins", pad_oe, 64'h0000_0003_A5A5_0F0F);
        check("R3 R4 pad_out pins", pad_out, 64'h0000_00F0_0000_0000);

        // R10: reset after configuration
        do_reset();
        rd(8, v);  check("R10 dir cleared", 64'(v), 64'd0);
        rd(40, v); check("R10 fall enable cleared", 64'(v), 64'd0);
        rd(68, v); check("R10 alt cleared", 64'(v), 64'd0);
        check("R10 pad_oe cleared", pad_oe, 64'd0);
        check("R10 pad_out cleared", pad_out, 64'd0);

        // R5: synchronizer latency
        @(negedge clk);
        pad_in[3] = 1'b1;
        @(negedge clk);
        rd(0, v); check("R5 level after one edge", 64'(v), 64'd0);
        @(negedge clk);
        rd(0, v); check("R5 level after two edges", 64'(v), 64'h8);

        // R7: edge with no enable
        repeat (3) @(negedge clk);
        rd(48, v); check("R7 unarmed rise", 64'(v), 64'd0);
        check("R7 irq unarmed", 64'(irq), 64'd0);

        // R6: rising capture on pin 5
        wr(32, 32'h20);
        pad_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        rd(48, v); check("R6 status not yet set", 64'(v), 64'd0);
        @(negedge clk);
        rd(48, v); check("R6 rise captured third edge", 64'(v), 64'h20);
        check("R11 irq with status", 64'(irq), 64'd1);

        // R8: clear; R11 irq drop
        wr(48, 32'h20);
        rd(48, v); check("R8 cleared", 64'(v), 64'd0);
        check("R11 irq cleared", 64'(irq), 64'd0);

        // R7: fall on rise-only pin
        pad_in[5] = 1'b0;
        repeat (4) @(negedge clk);
        rd(48, v); check("R7 fall ignored", 64'(v), 64'd0);

        // R6: both edges on pin 33
        wr(36, 32'h102);
        wr(44, 32'h2);
        pad_in[33] = 1'b1;
        repeat (4) @(negedge clk);
        rd(52, v); check("R6 both-enable rise", 64'(v), 64'h2);
        wr(52, 32'h2);
        pad_in[33] = 1'b0;
        repeat (4) @(negedge clk);
        rd(52, v); check("R6 both-enable fall", 64'(v), 64'h2);

        // R11: two pending, clear one
        pad_in[40] = 1'b1;
        repeat (4) @(negedge clk);
        rd(52, v); check("R6 pin 40 rise", 64'(v), 64'h102);
        wr(52, 32'h2);
        rd(52, v); check("R8 partial clear", 64'(v), 64'h100);
        check("R11 irq held with one pending", 64'(irq), 64'd1);

        // R8: edge coincides with clearing write
        pad_in[40] = 1'b0;
        repeat (4) @(negedge clk);
        pad_in[40] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 52; reg_wdata = 32'h100;
        @(negedge clk);
        reg_we = 1'b0;
        rd(52, v); check("R8 edge beats clear", 64'(v), 64'h100);
        check("R11 irq after race", 64'(irq), 64'd1);
        wr(52, 32'h100);
        rd(52, v); check("R8 final clear", 64'(v), 64'd0);
        check("R11 irq all clear", 64'(irq), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule